// File: doc/BRIEF.md
# S/PDIF Channel Status Capture and Decode

This block sits behind a recovered S/PDIF receiver front end. Each frame it receives one channel status bit per subframe (A and B) with a frame strobe. A block strobe marks the first frame of every 192-frame status block. The block assembles the first 32 status bits (four bytes) of each subframe into shadow registers. At the close of each block it copies them into software-visible registers. A busy flag reports that a capture is in progress and that the visible bytes may be replaced.

From the visible subframe A bytes, the block derives two summary outputs: an audio/non-audio indication and a compact two-bit sample-rate code. The rate field is taken from a place in the status data that depends on the professional/consumer bit. Both outputs are gated by a status-output enable. A separate enable routes the recovered user bit to an output pin. Biphase decoding, preamble detection and clock recovery happen upstream.

Top module: `cstat_capture`

## Requirements
- R1: In a block, the status bit from frame k (k counted from 0 at the block-start frame, k < 32) becomes bit k of the visible 32-bit vector. Byte n bit j therefore comes from frame 8n+j, with the first-received bit in bit 0 of each byte. Subframes A and B are captured independently.
- R2: capt_busy is 0 after reset. It is 1 from the clock cycle after a frame strobe that carries block_stb until the visible registers are reloaded.
- R3: The clock cycle after the frame strobe of frame index FRAMES_PER_BLOCK-1, the visible registers hold the newly captured bytes and capt_busy is 0. At no other time do the visible registers change.
- R4: Frame strobes with block_stb low are ignored while no block is in progress. This covers frames before the first block start and frames after a block completes. They do not set capt_busy and do not change the visible registers.
- R5: A frame strobe with block_stb during a block in progress restarts the capture at frame 0 and discards the partial block.
- R6: With stat_en = 1, nonaudio_o equals subframe A byte 0 bit 1 (0 = audio, 1 = non-audio).
- R7: Consumer format (A byte 0 bit 0 = 0): rate_code_o is taken from A byte 3 bits 3:0. The values are 0000 -> 00 (44.1 kHz), 0010 -> 01 (48 kHz), 0011 -> 11 (32 kHz), and any other value -> 10 (reserved).
- R8: Professional format (A byte 0 bit 0 = 1): rate_code_o is taken from A byte 0 bits 7:6. The values are 01 -> 00 (44.1 kHz), 10 -> 01 (48 kHz), 11 -> 11 (32 kHz), and 00 -> 10 (reserved).
- R9: With stat_en = 0, nonaudio_o and rate_code_o are both 0.
- R10: user_o is the value of user_bit from the previous clock cycle when user_en was 1 in that cycle. Otherwise user_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle pulse per frame; status bits valid with it |
| block_stb | input | 1 | Marks the frame strobe that is frame 0 of a block |
| cs_bit_a | input | 1 | Channel status bit of subframe A |
| cs_bit_b | input | 1 | Channel status bit of subframe B |
| user_bit | input | 1 | Recovered user bit |
| stat_en | input | 1 | Enables the decoded status outputs |
| user_en | input | 1 | Enables the user bit output |
| cs_bytes_a | output | 32 | Visible status bytes 0..3 of subframe A (byte n at bits 8n+7:8n) |
| cs_bytes_b | output | 32 | Visible status bytes 0..3 of subframe B |
| capt_busy | output | 1 | Capture in progress; visible bytes may change |
| nonaudio_o | output | 1 | Audio/non-audio indication |
| rate_code_o | output | 2 | Sample-rate code |
| user_o | output | 1 | Gated, registered user bit |

## Verification
The bench builds the block with FRAMES_PER_BLOCK = 48 instead of 192. This keeps each block short, so a run fits many full blocks, aborted blocks and ignored frame trains in few cycles. The value is still above the 32 captured frames, so the frames that are counted but not stored (indices 32..47) are exercised before each reload. Every consumer and professional rate pattern, including reserved values, is then reachable through complete blocks.

// File: rtl/cstat_pkg.sv
package cstat_pkg;

    typedef enum logic [1:0] {
        RATE_44K1 = 2'b00,
        RATE_48K  = 2'b01,
        RATE_RSVD = 2'b10,
        RATE_32K  = 2'b11
    } rate_code_e;

    // Map the sample-rate field to the compact code; pro selects the field.
    function automatic rate_code_e map_rate(input logic       pro,
                                            input logic [1:0] pro_fld,
                                            input logic [3:0] con_fld);
        rate_code_e r;
        r = RATE_RSVD;
        if (pro) begin
            case (pro_fld)
                2'b01:   r = RATE_44K1;
                2'b10:   r = RATE_48K;
                2'b11:   r = RATE_32K;
                default: r = RATE_RSVD;
            endcase
        end else begin
            case (con_fld)
                4'b0000: r = RATE_44K1;
                4'b0010: r = RATE_48K;
                4'b0011: r = RATE_32K;
                default: r = RATE_RSVD;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/cstat_seq.sv
module cstat_seq #(
    parameter int FRAMES_PER_BLOCK = 192,
    localparam int IDX_W = $clog2(FRAMES_PER_BLOCK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             block_stb,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             latch,
    output logic             busy
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES_PER_BLOCK - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [IDX_W-1:0] cur_idx;
    logic             active;
    logic             last;

    always_comb begin
        st_d    = st_q;
        cur_idx = block_stb ? '0 : st_q.idx;
        active  = frame_stb && (block_stb || st_q.busy);
        last    = active && (cur_idx == LAST_IDX);
        if (active) begin
            st_d.busy = !last;
            st_d.idx  = last ? '0 : cur_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en  = active;
    assign wr_idx = cur_idx;
    assign latch  = last;
    assign busy   = st_q.busy;
endmodule

// File: rtl/cstat_shadow.sv
module cstat_shadow #(
    parameter int BITS  = 32,
    parameter int IDX_W = 8,
    localparam int SEL_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             bit_in,
    output logic [BITS-1:0]  sh_next
);
    typedef struct packed {
        logic [BITS-1:0] sh;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_idx) < BITS))
            st_d.sh[wr_idx[SEL_W-1:0]] = bit_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Next value feeds the visible latch so a bit arriving with the last frame lands.
    assign sh_next = st_d.sh;
endmodule

// File: rtl/cstat_status.sv
module cstat_status
    import cstat_pkg::*;
#(
    parameter int BITS = 32
) (
    input  logic            stat_en,
    input  logic [BITS-1:0] vis_a,
    output logic            nonaudio,
    output logic [1:0]      rate
);
    rate_code_e code;

    always_comb begin
        code     = map_rate(vis_a[0], vis_a[7:6], vis_a[27:24]);
        nonaudio = stat_en & vis_a[1];
        rate     = stat_en ? code : 2'b00;
    end
endmodule

// File: rtl/cstat_capture.sv
module cstat_capture #(
    parameter int FRAMES_PER_BLOCK = 192,
    parameter int CAPT_BYTES       = 4,
    localparam int CAPT_BITS = 8 * CAPT_BYTES,
    localparam int IDX_W     = $clog2(FRAMES_PER_BLOCK),
    localparam int NCH       = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_stb,
    input  logic                 block_stb,
    input  logic                 cs_bit_a,
    input  logic                 cs_bit_b,
    input  logic                 user_bit,
    input  logic                 stat_en,
    input  logic                 user_en,
    output logic [CAPT_BITS-1:0] cs_bytes_a,
    output logic [CAPT_BITS-1:0] cs_bytes_b,
    output logic                 capt_busy,
    output logic                 nonaudio_o,
    output logic [1:0]           rate_code_o,
    output logic                 user_o
);
    typedef struct packed {
        logic [NCH-1:0][CAPT_BITS-1:0] vis;
        logic                          user;
    } top_state_t;

    top_state_t st_d, st_q;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             latch;
    logic [NCH-1:0]   cs_bit;
    logic [NCH-1:0][CAPT_BITS-1:0] sh_next;

    assign cs_bit = {cs_bit_b, cs_bit_a};

    cstat_seq #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .block_stb (block_stb),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .latch     (latch),
        .busy      (capt_busy)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        cstat_shadow #(.BITS(CAPT_BITS), .IDX_W(IDX_W)) i_shadow (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_idx  (wr_idx),
            .bit_in  (cs_bit[ch]),
            .sh_next (sh_next[ch])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.user = user_en & user_bit;
        if (latch) st_d.vis = sh_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cstat_status #(.BITS(CAPT_BITS)) i_status (
        .stat_en  (stat_en),
        .vis_a    (st_q.vis[0]),
        .nonaudio (nonaudio_o),
        .rate     (rate_code_o)
    );

    assign cs_bytes_a = st_q.vis[0];
    assign cs_bytes_b = st_q.vis[1];
    assign user_o     = st_q.user;
endmodule

// File: rtl/cstat_capture_chk.sv
module cstat_capture_chk #(
    parameter int BITS = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_stb,
    input logic            block_stb,
    input logic            user_en,
    input logic            stat_en,
    input logic [BITS-1:0] cs_bytes_a,
    input logic [BITS-1:0] cs_bytes_b,
    input logic            capt_busy,
    input logic            nonaudio_o,
    input logic [1:0]      rate_code_o,
    input logic            user_o
);
    // R2: a block start sets the busy flag
    a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && block_stb) |=> capt_busy);

    // R4: busy only rises after a block-start frame
    a_r4_no_spurious_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capt_busy) |-> $past(frame_stb && block_stb));

    // R3: visible bytes only change as busy ends
    a_r3_vis_a_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(capt_busy) |-> $stable(cs_bytes_a));
    a_r3_vis_b_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(capt_busy) |-> $stable(cs_bytes_b));

    // R6: non-audio follows byte 0 bit 1
    a_r6_nonaudio: assert property (@(posedge clk) disable iff (!rst_n)
        stat_en |-> (nonaudio_o == cs_bytes_a[1]));

    // R8: professional 32 kHz pattern
    a_r8_pro_32k: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_en && cs_bytes_a[0] && cs_bytes_a[7:6] == 2'b11) |-> (rate_code_o == 2'b11));

    // R9: gated status outputs
    a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_en |-> (!nonaudio_o && rate_code_o == 2'b00));

    // R10: user output silent one cycle after disable
    a_r10_user_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !user_en |=> !user_o);
endmodule

bind cstat_capture cstat_capture_chk #(.BITS(CAPT_BITS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_stb   (frame_stb),
    .block_stb   (block_stb),
    .user_en     (user_en),
    .stat_en     (stat_en),
    .cs_bytes_a  (cs_bytes_a),
    .cs_bytes_b  (cs_bytes_b),
    .capt_busy   (capt_busy),
    .nonaudio_o  (nonaudio_o),
    .rate_code_o (rate_code_o),
    .user_o      (user_o)
);

// File: tb/test_cstat_capture.sv
module test_cstat_capture;
    localparam int FPB = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0, block_stb = 1'b0;
    logic cs_bit_a = 1'b0, cs_bit_b = 1'b0;
    logic user_bit = 1'b0, stat_en = 1'b0, user_en = 1'b0;
    logic [31:0] cs_bytes_a, cs_bytes_b;
    logic capt_busy, nonaudio_o, user_o;
    logic [1:0] rate_code_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_a = '0, exp_b = '0;

    always #10 clk = ~clk;

    cstat_capture #(.FRAMES_PER_BLOCK(FPB)) i_cstat_capture (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .block_stb(block_stb),
        .cs_bit_a(cs_bit_a), .cs_bit_b(cs_bit_b), .user_bit(user_bit),
        .stat_en(stat_en), .user_en(user_en), .cs_bytes_a(cs_bytes_a),
        .cs_bytes_b(cs_bytes_b), .capt_busy(capt_busy), .nonaudio_o(nonaudio_o),
        .rate_code_o(rate_code_o), .user_o(user_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one frame strobe, then an idle cycle; ends at a negedge.
    task automatic frame(input logic start, input logic a, input logic b);
        @(negedge clk);
        frame_stb = 1'b1; block_stb = start; cs_bit_a = a; cs_bit_b = b;
        @(negedge clk);
        frame_stb = 1'b0; block_stb = 1'b0;
    endtask

    // Full block; checks busy after frame 0 and that visible bytes hold mid-block.
    task automatic run_block(input logic [31:0] a, input logic [31:0] b);
        for (int f = 0; f < FPB; f++) begin
            frame(f == 0, f < 32 ? a[f] : 1'b1, f < 32 ? b[f] : 1'b1);
            if (f == 0)  check("R2 busy after start", 32'(capt_busy), 32'd1);
            if (f == 40) check("R3 hold mid-block", cs_bytes_a, exp_a);
        end
        exp_a = a; exp_b = b;
        check("R3 busy low after last", 32'(capt_busy), 32'd0);
        check("R1 bytes A", cs_bytes_a, a);
        check("R1 bytes B", cs_bytes_b, b);
    endtask

    task automatic t_reset;
        check("R2 reset busy", 32'(capt_busy), 32'd0);
        check("R3 reset bytes A", cs_bytes_a, 32'd0);
        check("R10 reset user", 32'(user_o), 32'd0);
    endtask

    task automatic t_ignore_before_start;
        for (int f = 0; f < 10; f++) frame(1'b0, 1'b1, 1'b1);
        check("R4 no busy before start", 32'(capt_busy), 32'd0);
        check("R4 bytes untouched", cs_bytes_a, 32'd0);
    endtask

    task automatic t_capture;
        run_block(32'h8421_F00D, 32'h1234_5678);
        run_block(32'hA5C3_0F96, 32'h0000_0001);
        for (int f = 0; f < 12; f++) frame(1'b0, 1'b0, 1'b0);
        check("R4 ignored after block busy", 32'(capt_busy), 32'd0);
        check("R4 ignored after block A", cs_bytes_a, exp_a);
        check("R4 ignored after block B", cs_bytes_b, exp_b);
    endtask

    task automatic t_restart;
        for (int f = 0; f < 20; f++) frame(f == 0, 1'b1, 1'b1);
        check("R5 partial keeps old", cs_bytes_a, exp_a);
        run_block(32'h0F0F_3C3C, 32'hF0F0_C3C3);
        check("R5 restart result", cs_bytes_a, 32'h0F0F_3C3C);
    endtask

    task automatic t_status;
        stat_en = 1'b1;
        // consumer: byte0 bit0 = 0, field byte3[3:0]
        run_block({4'h0, 4'b0000, 24'h000002}, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R6 nonaudio", 32'(nonaudio_o), 32'd1);
        check("R7 cons 44.1", 32'(rate_code_o), 32'd0);
        run_block({4'h0, 4'b0010, 24'h000000}, 32'h0);
        @(negedge clk);
        check("R6 audio", 32'(nonaudio_o), 32'd0);
        check("R7 cons 48", 32'(rate_code_o), 32'd1);
        run_block({4'h0, 4'b0011, 24'h000000}, 32'h0);
        @(negedge clk);
        check("R7 cons 32", 32'(rate_code_o), 32'd3);
        run_block({4'h0, 4'b1000, 24'h000000}, 32'h0);
        @(negedge clk);
        check("R7 cons reserved", 32'(rate_code_o), 32'd2);
        // professional: byte0 bit0 = 1, field byte0[7:6]; byte3 set to distract
        run_block({4'h0, 4'b0011, 16'h0, 8'b0100_0001}, 32'h0);
        @(negedge clk);
        check("R8 pro 44.1", 32'(rate_code_o), 32'd0);
        run_block({4'h0, 4'b0000, 16'h0, 8'b1000_0001}, 32'h0);
        @(negedge clk);
        check("R8 pro 48", 32'(rate_code_o), 32'd1);
        run_block({4'h0, 4'b0010, 16'h0, 8'b1100_0001}, 32'h0);
        @(negedge clk);
        check("R8 pro 32", 32'(rate_code_o), 32'd3);
        run_block({4'h0, 4'b0000, 16'h0, 8'b0000_0011}, 32'h0);
        @(negedge clk);
        check("R8 pro reserved", 32'(rate_code_o), 32'd2);
        stat_en = 1'b0;
        @(negedge clk);
        check("R9 gated nonaudio", 32'(nonaudio_o), 32'd0);
        check("R9 gated rate", 32'(rate_code_o), 32'd0);
    endtask

    task automatic t_user;
        @(negedge clk); user_en = 1'b1; user_bit = 1'b1;
        @(negedge clk);
        check("R10 user pass 1", 32'(user_o), 32'd1);
        user_bit = 1'b0;
        @(negedge clk);
        check("R10 user pass 0", 32'(user_o), 32'd0);
        user_bit = 1'b1; user_en = 1'b0;
        @(negedge clk);
        check("R10 user gated", 32'(user_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignore_before_start();
        t_capture();
        t_restart();
        t_status();
        t_user();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule